// File: doc/BRIEF.md
# Snooping Cache Tag Store

This block holds the tag and valid state of a set-associative cache and gives it two independent read paths. The processor path looks an address up and reports hit or miss and the way that hit; a refill path writes a new tag into a chosen way and marks it valid. The second path watches the shared memory bus that the cache itself also drives. When another master, for example a DMA engine, writes to memory, the block looks the written address up in its own tag copy and drops the valid bit of any line it holds for that address, so the cache never returns stale data after a foreign write.

The data RAM, the refill sequencer, the replacement choice and the interconnect stay outside. The owner of the cache tells the block, through a sideband input, which bus cycles it issued itself; those are never treated as foreign writes. Address split (32-bit byte address): the low log2(LINE_BYTES) bits are the byte offset, the next log2(NUM_SETS) bits select the set, and the remaining upper bits form the tag. With the defaults (16 sets, 2 ways, 32-byte lines) that is offset [4:0], set [8:5], tag [31:9].

Top module: `snoop_tag_store`

## Requirements
- R1: After reset every line is invalid, so every lookup reports a miss.
- R2: A fill writes the tag of fill_addr into set fill_addr[set] of way fill_way and makes it valid; a lookup of that address from the next cycle on reports lk_hit=1 and lk_way equal to that way number. With lk_req low, lk_hit is 0.
- R3: A lookup hits only when both the set bits and the tag bits match a valid line; two different tags held in different ways of one set both hit, each with its own way number.
- R4: A foreign write whose set and tag bits match a valid line clears that line, and a lookup in the very next cycle reports a miss for it.
- R5: A bus cycle counts as a write only when bus_cyc, bus_stb and bus_we are all 1; if any of them is 0, no line is invalidated.
- R6: A write with bus_mine=1 (issued by this cache) invalidates nothing.
- R7: Snoop matching ignores the byte offset bits and is checked across all ways, clearing only the way whose tag matches; other ways of the same set stay valid.
- R8: A foreign write with the same tag but another set, or the same set but another tag, leaves the line valid.
- R9: When a snoop clear and a fill land on the same set and way in one cycle, the clear wins and the line ends invalid; this covers both a match on the old tag and a match on the tag being filled.
- R10: The lookup path is independent of the snoop path: during a snoop cycle, a lookup still returns the state held before that cycle's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Processor lookup request |
| lk_addr | input | 32 | Processor lookup byte address |
| lk_hit | output | 1 | Lookup hit, combinational from current state |
| lk_way | output | log2(NUM_WAYS) | Way number of the hit (lowest matching way), 0 on a miss |
| fill_en | input | 1 | Write a new tag and set its valid bit |
| fill_addr | input | 32 | Address of the line being filled |
| fill_way | input | log2(NUM_WAYS) | Way receiving the fill |
| bus_cyc | input | 1 | Shared bus cycle in progress |
| bus_stb | input | 1 | Shared bus strobe |
| bus_we | input | 1 | Shared bus write enable |
| bus_mine | input | 1 | High when the current bus cycle was issued by this cache |
| bus_adr | input | 32 | Shared bus byte address |

## Verification
The bench goes after the snoop filter at its edges: each qualifier dropped in turn and the self-issued flag, where a design that decoded the bus loosely would throw away lines on reads or on its own stores. It aims a snoop at one way of a two-way set with a non-zero offset, so a design that cleared the whole set or compared offset bits shows up as a lost neighbour or a surviving stale line. Near misses by one set or one tag catch a matcher that compares too few bits. Finally it collides a fill with a snoop on the same set and way, both on the old and on the new tag, where a design that let the fill win would leave a stale line valid.

// File: rtl/snoop_tag_pkg.sv
package snoop_tag_pkg;
  localparam int ADDR_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  // Index width for a count of items, at least one bit wide.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/snp_rst_sync.sv
module snp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/snp_tag_bank.sv
module snp_tag_bank import snoop_tag_pkg::*; #(
  parameter int SETS  = 16,
  parameter int TAG_W = 23
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [idx_bits(SETS)-1:0]  wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [idx_bits(SETS)-1:0]  rda_idx,
  output logic [TAG_W-1:0]           rda_tag,
  input  logic [idx_bits(SETS)-1:0]  rdb_idx,
  output logic [TAG_W-1:0]           rdb_tag
);
  // Tag storage carries no reset: validity lives in the valid bank.
  logic [TAG_W-1:0] mem_q [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_tag;
  end

  // Two asynchronous read ports: processor side and snoop side.
  assign rda_tag = mem_q[rda_idx];
  assign rdb_tag = mem_q[rdb_idx];
endmodule

// File: rtl/snp_valid_bank.sv
module snp_valid_bank import snoop_tag_pkg::*; #(
  parameter int SETS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [idx_bits(SETS)-1:0]  set_idx,
  input  logic                       clr_en,
  input  logic [idx_bits(SETS)-1:0]  clr_idx,
  input  logic [idx_bits(SETS)-1:0]  rda_idx,
  output logic                       rda,
  input  logic [idx_bits(SETS)-1:0]  rdb_idx,
  output logic                       rdb,
  output logic [SETS-1:0]            bits_o
);
  logic [SETS-1:0] vld_q;
  logic [SETS-1:0] vld_d;
  logic            upd_en;

  // Clear is applied after set, so a same-cycle collision ends invalid.
  always_comb begin
    vld_d = vld_q;
    if (set_en) vld_d[set_idx] = 1'b1;
    if (clr_en) vld_d[clr_idx] = 1'b0;
  end

  assign upd_en = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (upd_en) vld_q <= vld_d;
  end

  assign rda    = vld_q[rda_idx];
  assign rdb    = vld_q[rdb_idx];
  assign bits_o = vld_q;
endmodule

// File: rtl/snp_way_cmp.sv
module snp_way_cmp #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 23
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [WAYS-1:0]            hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = vld_i[w] && (tags_i[w] == key_i);
  end
endmodule

// File: rtl/snoop_tag_store.sv
module snoop_tag_store import snoop_tag_pkg::*; #(
  parameter int NUM_SETS   = 16,
  parameter int NUM_WAYS   = 2,
  parameter int LINE_BYTES = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lk_req,
  input  logic [31:0]                    lk_addr,
  output logic                           lk_hit,
  output logic [idx_bits(NUM_WAYS)-1:0]  lk_way,
  input  logic                           fill_en,
  input  logic [31:0]                    fill_addr,
  input  logic [idx_bits(NUM_WAYS)-1:0]  fill_way,
  input  logic                           bus_cyc,
  input  logic                           bus_stb,
  input  logic                           bus_we,
  input  logic                           bus_mine,
  input  logic [31:0]                    bus_adr
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W = idx_bits(NUM_SETS);
  localparam int WAY_W = idx_bits(NUM_WAYS);
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

  logic rst_s;

  snp_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  // Address fields for the three paths.
  logic [IDX_W-1:0] lk_idx, fill_idx, sn_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag, sn_tag;

  assign lk_idx   = lk_addr[OFS_W +: IDX_W];
  assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[OFS_W +: IDX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign sn_idx   = bus_adr[OFS_W +: IDX_W];
  assign sn_tag   = bus_adr[ADDR_W-1 -: TAG_W];

  logic unused_ofs;
  assign unused_ofs = ^{lk_addr[OFS_W-1:0], fill_addr[OFS_W-1:0], bus_adr[OFS_W-1:0]};

  // Foreign write qualification.
  logic snp_qual;
  assign snp_qual = bus_cyc & bus_stb & bus_we & ~bus_mine;

  logic [NUM_WAYS-1:0][TAG_W-1:0]    lk_tags, sn_tags;
  logic [NUM_WAYS-1:0]               lk_vld, sn_vld;
  logic [NUM_WAYS-1:0]               lk_hitv, sn_hitv;
  logic [NUM_WAYS-1:0]               fill_sel;
  logic [NUM_WAYS-1:0]               snp_clr;
  logic [NUM_WAYS-1:0][NUM_SETS-1:0] way_bits;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0] vld_sw;
  logic                              fill_same_line;

  // The snooped line may also be the one being filled this cycle.
  assign fill_same_line = (fill_idx == sn_idx) && (fill_tag == sn_tag);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign fill_sel[w] = fill_en && (fill_way == WAY_W'(w));
    assign snp_clr[w]  = snp_qual && (sn_hitv[w] || (fill_sel[w] && fill_same_line));

    snp_tag_bank #(
      .SETS  (NUM_SETS),
      .TAG_W (TAG_W)
    ) u_tag (
      .clk     (clk),
      .wr_en   (fill_sel[w]),
      .wr_idx  (fill_idx),
      .wr_tag  (fill_tag),
      .rda_idx (lk_idx),
      .rda_tag (lk_tags[w]),
      .rdb_idx (sn_idx),
      .rdb_tag (sn_tags[w])
    );

    snp_valid_bank #(
      .SETS (NUM_SETS)
    ) u_vld (
      .clk     (clk),
      .rst_n   (rst_s),
      .set_en  (fill_sel[w]),
      .set_idx (fill_idx),
      .clr_en  (snp_clr[w]),
      .clr_idx (sn_idx),
      .rda_idx (lk_idx),
      .rda     (lk_vld[w]),
      .rdb_idx (sn_idx),
      .rdb     (sn_vld[w]),
      .bits_o  (way_bits[w])
    );
  end

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        vld_sw[s][w] = way_bits[w][s];
      end
    end
  end

  snp_way_cmp #(
    .WAYS  (NUM_WAYS),
    .TAG_W (TAG_W)
  ) u_lk_cmp (
    .tags_i (lk_tags),
    .vld_i  (lk_vld),
    .key_i  (lk_tag),
    .hit_o  (lk_hitv)
  );

  snp_way_cmp #(
    .WAYS  (NUM_WAYS),
    .TAG_W (TAG_W)
  ) u_sn_cmp (
    .tags_i (sn_tags),
    .vld_i  (sn_vld),
    .key_i  (sn_tag),
    .hit_o  (sn_hitv)
  );

  // Processor result: lowest matching way wins the encode.
  always_comb begin
    lk_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (lk_hitv[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_hit = lk_req && (|lk_hitv);
endmodule

// File: rtl/snoop_tag_store_chk.sv
module snoop_tag_store_chk import snoop_tag_pkg::*; #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 2
) (
  input logic                                clk,
  input logic                                rst_s,
  input logic                                bus_cyc,
  input logic                                bus_stb,
  input logic                                bus_we,
  input logic                                bus_mine,
  input logic [NUM_WAYS-1:0]                 snp_clr,
  input logic                                fill_en,
  input logic [idx_bits(NUM_WAYS)-1:0]       fill_way,
  input logic [idx_bits(NUM_SETS)-1:0]       fill_idx,
  input logic [idx_bits(NUM_SETS)-1:0]       sn_idx,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0]   vld_sw
);
  localparam int WAY_W = idx_bits(NUM_WAYS);

  assert_unqualified_quiet_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !(bus_cyc && bus_stb && bus_we) |-> (snp_clr == '0))
    else $error("R5: clear without a full write qualification");

  assert_own_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_s)
    bus_mine |-> (snp_clr == '0))
    else $error("R6: own write caused an invalidation");

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_w
    assert_snoop_clears_R4: assert property (@(posedge clk) disable iff (!rst_s)
      snp_clr[w] |=> !vld_sw[$past(sn_idx)][w])
      else $error("R4: snooped line still valid");

    assert_fill_sets_R2: assert property (@(posedge clk) disable iff (!rst_s)
      (fill_en && (fill_way == WAY_W'(w)) && !snp_clr[w]) |=> vld_sw[$past(fill_idx)][w])
      else $error("R2: filled line not valid");

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_s)
      (fill_en && (fill_way == WAY_W'(w)) && snp_clr[w] && (fill_idx == sn_idx))
        |=> !vld_sw[$past(fill_idx)][w])
      else $error("R9: fill beat a same-cycle snoop clear");
  end
endmodule

bind snoop_tag_store snoop_tag_store_chk #(
  .NUM_SETS (NUM_SETS),
  .NUM_WAYS (NUM_WAYS)
) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .bus_cyc  (bus_cyc),
  .bus_stb  (bus_stb),
  .bus_we   (bus_we),
  .bus_mine (bus_mine),
  .snp_clr  (snp_clr),
  .fill_en  (fill_en),
  .fill_way (fill_way),
  .fill_idx (fill_idx),
  .sn_idx   (sn_idx),
  .vld_sw   (vld_sw)
);

// File: tb/snoop_tag_store_tb.sv
module snoop_tag_store_tb;
  // Defaults: 16 sets, 2 ways, 32-byte lines -> offset [4:0], set [8:5], tag [31:9].
  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic [0:0]  lk_way;
  logic        fill_en;
  logic [31:0] fill_addr;
  logic [0:0]  fill_way;
  logic        bus_cyc, bus_stb, bus_we, bus_mine;
  logic [31:0] bus_adr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  snoop_tag_store u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_way    (lk_way),
    .fill_en   (fill_en),
    .fill_addr (fill_addr),
    .fill_way  (fill_way),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_mine  (bus_mine),
    .bus_adr   (bus_adr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input int tag, input int set, input int ofs);
    logic [22:0] t = tag[22:0];
    logic [3:0]  s = set[3:0];
    logic [4:0]  o = ofs[4:0];
    return {t, s, o};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Combinational lookup, checked inside the low clock phase.
  task automatic look(input logic [31:0] a, input bit exp_hit, input int exp_way, input string rq);
    lk_req  = 1'b1;
    lk_addr = a;
    #1;
    chk(lk_hit == exp_hit, {rq, " hit"}, int'(lk_hit), int'(exp_hit));
    if (exp_hit) chk(int'(lk_way) == exp_way, {rq, " way"}, int'(lk_way), exp_way);
    lk_req = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic [31:0] a, input int way);
    fill_en   = 1'b1;
    fill_addr = a;
    fill_way  = way[0:0];
    step();
    fill_en = 1'b0;
  endtask

  task automatic bus_wr(input logic [31:0] a, input bit c, input bit s, input bit w, input bit m);
    bus_cyc = c; bus_stb = s; bus_we = w; bus_mine = m; bus_adr = a;
    step();
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_mine = 0;
  endtask

  task automatic t_reset();
    look(mk(0, 0, 0), 0, 0, "R1 set0");
    look(mk(5, 3, 0), 0, 0, "R1 set3");
    look(mk(23'h7fffff, 15, 31), 0, 0, "R1 set15");
  endtask

  task automatic t_fill();
    fill(mk(16'h1234, 3, 0), 0);
    fill(mk(16'h0055, 3, 0), 1);
    look(mk(16'h1234, 3, 8), 1, 0, "R2 way0");
    look(mk(16'h0055, 3, 0), 1, 1, "R3 way1 same set");
    lk_addr = mk(16'h1234, 3, 0);
    #1;
    chk(lk_hit == 1'b0, "R2 no req", int'(lk_hit), 0);
    look(mk(16'h0777, 3, 0), 0, 0, "R3 other tag");
    look(mk(16'h1234, 4, 0), 0, 0, "R3 other set");
  endtask

  task automatic t_qual();
    bus_wr(mk(16'h1234, 3, 0), 0, 1, 1, 0);
    look(mk(16'h1234, 3, 0), 1, 0, "R5 no cyc");
    bus_wr(mk(16'h1234, 3, 0), 1, 0, 1, 0);
    look(mk(16'h1234, 3, 0), 1, 0, "R5 no stb");
    bus_wr(mk(16'h1234, 3, 0), 1, 1, 0, 0);
    look(mk(16'h1234, 3, 0), 1, 0, "R5 read");
    bus_wr(mk(16'h1234, 3, 0), 1, 1, 1, 1);
    look(mk(16'h1234, 3, 0), 1, 0, "R6 own write");
  endtask

  task automatic t_snoop();
    bus_wr(mk(16'h0055, 3, 28), 1, 1, 1, 0);
    look(mk(16'h0055, 3, 0), 0, 0, "R4 cleared next cycle");
    look(mk(16'h1234, 3, 0), 1, 0, "R7 other way kept");
  endtask

  task automatic t_near();
    fill(mk(16'h0099, 7, 0), 0);
    bus_wr(mk(16'h0099, 8, 0), 1, 1, 1, 0);
    look(mk(16'h0099, 7, 0), 1, 0, "R8 other set");
    bus_wr(mk(16'h0098, 7, 0), 1, 1, 1, 0);
    look(mk(16'h0099, 7, 0), 1, 0, "R8 other tag");
  endtask

  task automatic t_parallel();
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_mine = 0; bus_adr = mk(16'h0099, 7, 4);
    look(mk(16'h0099, 7, 0), 1, 0, "R10 before edge");
    look(mk(16'h1234, 3, 0), 1, 0, "R10 other line");
    step();
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    look(mk(16'h0099, 7, 0), 0, 0, "R10 after edge");
  endtask

  task automatic t_collide();
    // Old-tag match: line holds 0x42, fill writes 0x43, snoop hits 0x42.
    fill(mk(16'h0042, 5, 0), 1);
    look(mk(16'h0042, 5, 0), 1, 1, "R2 pre collide");
    fill_en = 1; fill_addr = mk(16'h0043, 5, 0); fill_way = 1'b1;
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_mine = 0; bus_adr = mk(16'h0042, 5, 0);
    step();
    fill_en = 0; bus_cyc = 0; bus_stb = 0; bus_we = 0;
    look(mk(16'h0043, 5, 0), 0, 0, "R9 old tag clear wins");
    look(mk(16'h0042, 5, 0), 0, 0, "R9 old line gone");
    // New-tag match: empty line filled with 0x60 while 0x60 is written.
    fill_en = 1; fill_addr = mk(16'h0060, 9, 0); fill_way = 1'b0;
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_mine = 0; bus_adr = mk(16'h0060, 9, 12);
    step();
    fill_en = 0; bus_cyc = 0; bus_stb = 0; bus_we = 0;
    look(mk(16'h0060, 9, 0), 0, 0, "R9 new tag clear wins");
  endtask

  initial begin
    rst_n = 0; lk_req = 0; lk_addr = '0; fill_en = 0; fill_addr = '0; fill_way = '0;
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_mine = 0; bus_adr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_qual();
    t_snoop();
    t_near();
    t_parallel();
    t_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule